// File: doc/BRIEF.md
# Scoreboarded Warp Issue Scheduler

This block sits between instruction fetch and the execution lanes of a small multithreaded processor. It keeps one buffered instruction per warp. A fetch port fills at most one empty slot per cycle. A pending-write table holds one bit per warp per register, and it blocks any slot whose source registers or destination register still wait on a writeback. Each cycle a rotating priority picks at most one eligible warp. The picked instruction then occupies the issue port for several consecutive beats. In each beat, one group of lanes receives the same instruction.

A warp stalled on an operand never holds up the others. Long-latency memory results can therefore return out of order through the writeback port while other warps keep issuing. A writeback that arrives in the same cycle as an eligibility check counts immediately. The unblocked warp can then be picked in that cycle.

Top module: `warp_issue_sched`

## Requirements
- R1: After reset, issue_valid is low, every warp's slot is empty (fetch_ready is high for any fetch_warp), and no register of any warp is pending.
- R2: fetch_ready equals 1 exactly when the slot of fetch_warp is empty. A fetch with fetch_ready low is dropped and leaves the buffered instruction of that warp unchanged. An accepted fetch makes its slot eligible from the next cycle on.
- R3: A buffered instruction is not picked while any of its source register fields (fetch_src bits [3:0] and [7:4]) names a register that is pending for its warp.
- R4: When fetch_dst_en is 1, a buffered instruction is not picked while its destination register is pending for its warp. When fetch_dst_en is 0, the destination field is ignored.
- R5: Picking an instruction with dst_en set marks its destination register pending for its warp. A writeback clears only the bit that matches both wb_warp and wb_reg.
- R6: A writeback that clears the last blocking register of a slot lets that slot be picked on the same clock edge, so its first beat appears in the next cycle.
- R7: A picked instruction is presented for exactly LANES/LANE_GROUP = 4 consecutive cycles with issue_valid high. issue_lane_grp counts 0,1,2,3, and warp, dst, dst_en and src stay constant.
- R8: No new pick happens before the last beat. When an eligible warp exists during the last beat, the next instruction's beat 0 follows in the very next cycle.
- R9: The search for a pick starts at the warp after the one picked last (warp 0 after reset) and wraps around. The first eligible warp found wins.
- R10: A warp blocked on a pending register does not stop other eligible warps from being picked.
- R11: issue_valid is low in any cycle after the last beat when no warp was eligible at that pick point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_valid | input | 1 | Fetch offers an instruction |
| fetch_warp | input | 3 | Warp the offered instruction belongs to |
| fetch_dst | input | 4 | Destination register |
| fetch_dst_en | input | 1 | Instruction writes its destination |
| fetch_src | input | 8 | Two source registers, source 0 in bits [3:0] |
| fetch_ready | output | 1 | Slot of fetch_warp is empty |
| wb_valid | input | 1 | A result is written back |
| wb_warp | input | 3 | Warp of the writeback |
| wb_reg | input | 4 | Register of the writeback |
| issue_valid | output | 1 | A beat of an issued instruction is presented |
| issue_warp | output | 3 | Warp being issued |
| issue_dst | output | 4 | Destination register being issued |
| issue_dst_en | output | 1 | Destination write flag being issued |
| issue_src | output | 8 | Source registers being issued |
| issue_lane_grp | output | 2 | Lane group served in this beat |

## Verification
Three events can land on the same clock edge: a writeback that releases a register, the eligibility decision that reads that register, and the last beat of the current dispatch. The bench drives a writeback for a blocked warp's source or destination register while a dispatch is in its final beat. A cycle-level reference model predicts that the freed warp starts its first beat in the next cycle. The bench also stacks back-to-back picks across all eight warps and checks every beat against the model. Writebacks to the wrong warp or the wrong register are sent as well, and the bench confirms that the blocked slot stays silent.

// File: rtl/warp_issue_pkg.sv
package warp_issue_pkg;
   localparam int unsigned DEF_NUM_WARPS  = 8;
   localparam int unsigned DEF_NUM_REGS   = 16;
   localparam int unsigned DEF_NUM_SRC    = 2;
   localparam int unsigned DEF_LANES      = 32;
   localparam int unsigned DEF_LANE_GROUP = 8;

   typedef enum logic {
      DISP_IDLE = 1'b0,
      DISP_BUSY = 1'b1
   } disp_state_e;
endpackage

// File: rtl/warp_issue_scoreboard.sv
module warp_issue_scoreboard #(
   parameter int unsigned NUM_WARPS = 8,
   parameter int unsigned NUM_REGS  = 16,
   localparam int unsigned WW = $clog2(NUM_WARPS),
   localparam int unsigned RW = $clog2(NUM_REGS)
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               wb_valid,
   input  logic [WW-1:0]                      wb_warp,
   input  logic [RW-1:0]                      wb_reg,
   input  logic                               set_valid,
   input  logic [WW-1:0]                      set_warp,
   input  logic [RW-1:0]                      set_reg,
   output logic [NUM_WARPS-1:0][NUM_REGS-1:0] pend_eff
);
   logic [NUM_WARPS-1:0][NUM_REGS-1:0] pend_q;

   for (genvar w = 0; w < NUM_WARPS; w++) begin : g_warp
      for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
         logic wb_hit;
         logic set_hit;
         assign wb_hit  = wb_valid  && (wb_warp  == WW'(w)) && (wb_reg  == RW'(r));
         assign set_hit = set_valid && (set_warp == WW'(w)) && (set_reg == RW'(r));
         // same-edge writeback is visible to the eligibility check
         assign pend_eff[w][r] = pend_q[w][r] & ~wb_hit;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       pend_q[w][r] <= 1'b0;
            else if (set_hit) pend_q[w][r] <= 1'b1;
            else if (wb_hit)  pend_q[w][r] <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/warp_issue_slots.sv
module warp_issue_slots #(
   parameter int unsigned NUM_WARPS = 8,
   parameter int unsigned NUM_REGS  = 16,
   parameter int unsigned NUM_SRC   = 2,
   localparam int unsigned WW = $clog2(NUM_WARPS),
   localparam int unsigned RW = $clog2(NUM_REGS)
) (
   input  logic                                       clk,
   input  logic                                       rst_n,
   input  logic                                       fetch_valid,
   input  logic [WW-1:0]                              fetch_warp,
   input  logic [RW-1:0]                              fetch_dst,
   input  logic                                       fetch_dst_en,
   input  logic [NUM_SRC*RW-1:0]                      fetch_src,
   output logic                                       fetch_ready,
   input  logic                                       pop_valid,
   input  logic [WW-1:0]                              pop_warp,
   output logic [NUM_WARPS-1:0]                       slot_valid,
   output logic [NUM_WARPS-1:0][RW-1:0]               slot_dst,
   output logic [NUM_WARPS-1:0]                       slot_dst_en,
   output logic [NUM_WARPS-1:0][NUM_SRC-1:0][RW-1:0]  slot_src
);
   assign fetch_ready = ~slot_valid[fetch_warp];

   for (genvar w = 0; w < NUM_WARPS; w++) begin : g_slot
      logic fill;
      logic drain;
      assign fill  = fetch_valid && (fetch_warp == WW'(w)) && !slot_valid[w];
      assign drain = pop_valid && (pop_warp == WW'(w));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            slot_valid[w]  <= 1'b0;
            slot_dst[w]    <= '0;
            slot_dst_en[w] <= 1'b0;
            slot_src[w]    <= '0;
         end else if (drain) begin
            slot_valid[w]  <= 1'b0;
         end else if (fill) begin
            slot_valid[w]  <= 1'b1;
            slot_dst[w]    <= fetch_dst;
            slot_dst_en[w] <= fetch_dst_en;
            slot_src[w]    <= fetch_src;
         end
      end
   end
endmodule

// File: rtl/warp_issue_picker.sv
module warp_issue_picker #(
   parameter int unsigned NUM_WARPS = 8,
   localparam int unsigned WW = $clog2(NUM_WARPS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_WARPS-1:0] req,
   input  logic                 take,
   output logic                 grant_valid,
   output logic [WW-1:0]        grant_idx
);
   logic [WW-1:0] ptr_q;

   always_comb begin
      logic [WW-1:0] idx;
      grant_valid = 1'b0;
      grant_idx   = '0;
      // descending scan so the smallest offset from ptr_q wins
      for (int i = NUM_WARPS - 1; i >= 0; i--) begin
         idx = ptr_q + WW'(i);
         if (req[idx]) begin
            grant_valid = 1'b1;
            grant_idx   = idx;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   ptr_q <= '0;
      else if (take && grant_valid) ptr_q <= grant_idx + 1'b1;
   end
endmodule

// File: rtl/warp_issue_sched.sv
module warp_issue_sched
   import warp_issue_pkg::*;
#(
   parameter int unsigned NUM_WARPS  = DEF_NUM_WARPS,
   parameter int unsigned NUM_REGS   = DEF_NUM_REGS,
   parameter int unsigned NUM_SRC    = DEF_NUM_SRC,
   parameter int unsigned LANES      = DEF_LANES,
   parameter int unsigned LANE_GROUP = DEF_LANE_GROUP,
   localparam int unsigned WW    = $clog2(NUM_WARPS),
   localparam int unsigned RW    = $clog2(NUM_REGS),
   localparam int unsigned BEATS = LANES / LANE_GROUP,
   localparam int unsigned BW    = $clog2(BEATS)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  fetch_valid,
   input  logic [WW-1:0]         fetch_warp,
   input  logic [RW-1:0]         fetch_dst,
   input  logic                  fetch_dst_en,
   input  logic [NUM_SRC*RW-1:0] fetch_src,
   output logic                  fetch_ready,
   input  logic                  wb_valid,
   input  logic [WW-1:0]         wb_warp,
   input  logic [RW-1:0]         wb_reg,
   output logic                  issue_valid,
   output logic [WW-1:0]         issue_warp,
   output logic [RW-1:0]         issue_dst,
   output logic                  issue_dst_en,
   output logic [NUM_SRC*RW-1:0] issue_src,
   output logic [BW-1:0]         issue_lane_grp
);
   localparam logic [BW-1:0] LAST_BEAT = BW'(BEATS - 1);

   // elaboration checks on the parameter set
   if (NUM_WARPS < 2 || (NUM_WARPS & (NUM_WARPS - 1)) != 0)
      $error("NUM_WARPS must be a power of two of at least 2");
   if (NUM_REGS < 2 || (NUM_REGS & (NUM_REGS - 1)) != 0)
      $error("NUM_REGS must be a power of two of at least 2");
   if (NUM_SRC < 1)
      $error("NUM_SRC must be at least 1");
   if (LANE_GROUP == 0 || (LANES % LANE_GROUP) != 0)
      $error("LANES must be a multiple of LANE_GROUP");
   if (BEATS < 2 || (BEATS & (BEATS - 1)) != 0)
      $error("LANES/LANE_GROUP must be a power of two of at least 2");

   logic [NUM_WARPS-1:0]                      slot_valid;
   logic [NUM_WARPS-1:0][RW-1:0]              slot_dst;
   logic [NUM_WARPS-1:0]                      slot_dst_en;
   logic [NUM_WARPS-1:0][NUM_SRC-1:0][RW-1:0] slot_src;
   logic [NUM_WARPS-1:0][NUM_REGS-1:0]        pend_eff;
   logic [NUM_WARPS-1:0]                      eligible;
   logic                                      grant_valid;
   logic [WW-1:0]                             grant_idx;
   logic                                      pick_window;
   logic                                      pick;
   disp_state_e                               state_q;
   logic [BW-1:0]                             beat_q;

   warp_issue_slots #(
      .NUM_WARPS(NUM_WARPS), .NUM_REGS(NUM_REGS), .NUM_SRC(NUM_SRC)
   ) u_slots (
      .clk(clk), .rst_n(rst_n),
      .fetch_valid(fetch_valid), .fetch_warp(fetch_warp), .fetch_dst(fetch_dst),
      .fetch_dst_en(fetch_dst_en), .fetch_src(fetch_src), .fetch_ready(fetch_ready),
      .pop_valid(pick), .pop_warp(grant_idx),
      .slot_valid(slot_valid), .slot_dst(slot_dst),
      .slot_dst_en(slot_dst_en), .slot_src(slot_src)
   );

   warp_issue_scoreboard #(
      .NUM_WARPS(NUM_WARPS), .NUM_REGS(NUM_REGS)
   ) u_sb (
      .clk(clk), .rst_n(rst_n),
      .wb_valid(wb_valid), .wb_warp(wb_warp), .wb_reg(wb_reg),
      .set_valid(pick && slot_dst_en[grant_idx]),
      .set_warp(grant_idx), .set_reg(slot_dst[grant_idx]),
      .pend_eff(pend_eff)
   );

   for (genvar w = 0; w < NUM_WARPS; w++) begin : g_elig
      always_comb begin
         eligible[w] = slot_valid[w];
         for (int s = 0; s < NUM_SRC; s++) begin
            if (pend_eff[w][slot_src[w][s]]) eligible[w] = 1'b0;
         end
         if (slot_dst_en[w] && pend_eff[w][slot_dst[w]]) eligible[w] = 1'b0;
      end
   end

   warp_issue_picker #(
      .NUM_WARPS(NUM_WARPS)
   ) u_pick (
      .clk(clk), .rst_n(rst_n),
      .req(eligible), .take(pick_window),
      .grant_valid(grant_valid), .grant_idx(grant_idx)
   );

   assign pick_window = (state_q == DISP_IDLE) || (beat_q == LAST_BEAT);
   assign pick        = pick_window && grant_valid;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q      <= DISP_IDLE;
         beat_q       <= '0;
         issue_warp   <= '0;
         issue_dst    <= '0;
         issue_dst_en <= 1'b0;
         issue_src    <= '0;
      end else if (pick) begin
         state_q      <= DISP_BUSY;
         beat_q       <= '0;
         issue_warp   <= grant_idx;
         issue_dst    <= slot_dst[grant_idx];
         issue_dst_en <= slot_dst_en[grant_idx];
         issue_src    <= slot_src[grant_idx];
      end else if (state_q == DISP_BUSY) begin
         if (beat_q == LAST_BEAT) state_q <= DISP_IDLE;
         else                     beat_q  <= beat_q + 1'b1;
      end
   end

   assign issue_valid    = (state_q == DISP_BUSY);
   assign issue_lane_grp = beat_q;
endmodule

// File: rtl/warp_issue_sched_chk.sv
module warp_issue_sched_chk #(
   parameter int unsigned WW    = 3,
   parameter int unsigned RW    = 4,
   parameter int unsigned BW    = 2,
   parameter int unsigned BEATS = 4
) (
   input logic          clk,
   input logic          rst_n,
   input logic          fetch_valid,
   input logic [WW-1:0] fetch_warp,
   input logic          fetch_ready,
   input logic          issue_valid,
   input logic [WW-1:0] issue_warp,
   input logic [RW-1:0] issue_dst,
   input logic [BW-1:0] issue_lane_grp
);
   localparam logic [BW-1:0] LAST = BW'(BEATS - 1);

   p_reset_idle_r1: assert property (@(posedge clk)
      !rst_n |=> !issue_valid);

   p_beat_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
      issue_valid && issue_lane_grp != LAST
      |=> issue_valid && issue_lane_grp == $past(issue_lane_grp) + 1'b1);

   p_hold_fields_r7: assert property (@(posedge clk) disable iff (!rst_n)
      issue_valid && issue_lane_grp != LAST
      |=> $stable(issue_warp) && $stable(issue_dst));

   p_first_beat_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(issue_valid) |-> issue_lane_grp == '0);

   p_fill_blocks_r2: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_valid && fetch_ready |=> ($stable(fetch_warp) -> !fetch_ready));
endmodule

bind warp_issue_sched warp_issue_sched_chk #(
   .WW(WW), .RW(RW), .BW(BW), .BEATS(BEATS)
) u_chk (
   .clk(clk), .rst_n(rst_n),
   .fetch_valid(fetch_valid), .fetch_warp(fetch_warp), .fetch_ready(fetch_ready),
   .issue_valid(issue_valid), .issue_warp(issue_warp), .issue_dst(issue_dst),
   .issue_lane_grp(issue_lane_grp)
);

// File: tb/warp_issue_sched_bench.sv
`timescale 1ns/1ps
module warp_issue_sched_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       fetch_valid = 1'b0;
   logic [2:0] fetch_warp = '0;
   logic [3:0] fetch_dst = '0;
   logic       fetch_dst_en = 1'b0;
   logic [7:0] fetch_src = '0;
   logic       fetch_ready;
   logic       wb_valid = 1'b0;
   logic [2:0] wb_warp = '0;
   logic [3:0] wb_reg = '0;
   logic       issue_valid;
   logic [2:0] issue_warp;
   logic [3:0] issue_dst;
   logic       issue_dst_en;
   logic [7:0] issue_src;
   logic [1:0] issue_lane_grp;

   always #4 clk = ~clk;

   warp_issue_sched u_warp_issue_sched (
      .clk(clk), .rst_n(rst_n),
      .fetch_valid(fetch_valid), .fetch_warp(fetch_warp), .fetch_dst(fetch_dst),
      .fetch_dst_en(fetch_dst_en), .fetch_src(fetch_src), .fetch_ready(fetch_ready),
      .wb_valid(wb_valid), .wb_warp(wb_warp), .wb_reg(wb_reg),
      .issue_valid(issue_valid), .issue_warp(issue_warp), .issue_dst(issue_dst),
      .issue_dst_en(issue_dst_en), .issue_src(issue_src), .issue_lane_grp(issue_lane_grp)
   );

   int    n_cmp = 0;
   int    n_bad = 0;
   string cur_req = "R1";
   bit    done = 1'b0;

   // behavioural reference state
   bit m_sv[8];
   int m_dst[8];
   bit m_den[8];
   int m_s0[8];
   int m_s1[8];
   bit m_pend[8][16];
   bit m_busy;
   int m_beat, m_ptr, m_iw, m_id, m_ide, m_is0, m_is1;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         foreach (m_sv[w]) begin
            m_sv[w] = 0; m_dst[w] = 0; m_den[w] = 0; m_s0[w] = 0; m_s1[w] = 0;
            for (int r = 0; r < 16; r++) m_pend[w][r] = 0;
         end
         m_busy = 0; m_beat = 0; m_ptr = 0;
         m_iw = 0; m_id = 0; m_ide = 0; m_is0 = 0; m_is1 = 0;
      end else begin
         int  pick;
         bit  blk;
         bit  fv;
         int  fw;
         pick = -1;
         if (wb_valid) m_pend[wb_warp][wb_reg] = 0;   // writeback first
         fv = fetch_valid;
         fw = int'(fetch_warp);
         if (!m_busy || m_beat == 3) begin
            for (int k = 0; k < 8; k++) begin
               int w;
               w = (m_ptr + k) % 8;
               blk = m_pend[w][m_s0[w]] || m_pend[w][m_s1[w]] ||
                     (m_den[w] && m_pend[w][m_dst[w]]);
               if (pick < 0 && m_sv[w] && !blk) pick = w;
            end
         end
         if (fv && !m_sv[fw]) begin
            m_sv[fw]  = 1;
            m_dst[fw] = int'(fetch_dst);
            m_den[fw] = fetch_dst_en;
            m_s0[fw]  = int'(fetch_src[3:0]);
            m_s1[fw]  = int'(fetch_src[7:4]);
         end
         if (pick >= 0) begin
            m_sv[pick] = 0;
            if (m_den[pick]) m_pend[pick][m_dst[pick]] = 1;
            m_busy = 1; m_beat = 0; m_ptr = (pick + 1) % 8;
            m_iw = pick; m_id = m_dst[pick]; m_ide = m_den[pick];
            m_is0 = m_s0[pick]; m_is1 = m_s1[pick];
         end else if (m_busy) begin
            if (m_beat == 3) m_busy = 0;
            else m_beat = m_beat + 1;
         end
      end
   end

   task automatic check(string req, string what, int act, int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
      end
   endtask

   task automatic compare_outputs();
      check(cur_req, "issue_valid", int'(issue_valid), int'(m_busy));
      if (m_busy) begin
         check(cur_req, "issue_warp", int'(issue_warp), m_iw);
         check(cur_req, "issue_dst", int'(issue_dst), m_id);
         check(cur_req, "issue_dst_en", int'(issue_dst_en), m_ide);
         check(cur_req, "issue_src", int'(issue_src), m_is1 * 16 + m_is0);
         check(cur_req, "issue_lane_grp", int'(issue_lane_grp), m_beat);
      end
   endtask

   task automatic cyc(int n = 1);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         @(negedge clk);
         compare_outputs();
      end
   endtask

   task automatic fetch(int w, int d, bit den, int s0, int s1);
      fetch_valid = 1; fetch_warp = 3'(w); fetch_dst = 4'(d);
      fetch_dst_en = den; fetch_src = {4'(s1), 4'(s0)};
      #1;
      check("R2", "fetch_ready", int'(fetch_ready), int'(!m_sv[w]));
      cyc();
      fetch_valid = 0;
   endtask

   task automatic wback(int w, int r);
      wb_valid = 1; wb_warp = 3'(w); wb_reg = 4'(r);
      cyc();
      wb_valid = 0;
   endtask

   initial begin
      #80000;
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      // R1: reset state
      cur_req = "R1";
      #20;
      @(negedge clk);
      rst_n = 1;
      check("R1", "issue_valid after reset", int'(issue_valid), 0);
      for (int w = 0; w < 8; w++) begin
         fetch_warp = 3'(w);
         #1;
         check("R1", "fetch_ready empty slot", int'(fetch_ready), 1);
      end
      cyc(2);

      // R7: plain instruction dispatched over four beats
      cur_req = "R7";
      fetch(2, 5, 1, 1, 3);
      cyc(6);

      // R3 / R10: warp 2 waits on r5, warp 4 goes ahead
      cur_req = "R10";
      fetch(2, 6, 1, 5, 0);
      fetch(4, 9, 1, 2, 2);
      cyc(8);
      cur_req = "R11";
      cyc(3);
      check("R3", "blocked warp stays silent", int'(issue_valid), 0);

      // R6: writeback releases the source on the same edge
      cur_req = "R6";
      wback(2, 5);
      check("R6", "issue starts after same-edge writeback", int'(issue_valid), 1);
      cyc(5);

      // R4: destination already pending
      cur_req = "R4";
      fetch(2, 6, 1, 0, 1);
      cyc(4);
      check("R4", "write-after-write held", int'(issue_valid), 0);
      wback(2, 6);
      cyc(5);

      // R9 / R8: all warps eligible, rotating order and back-to-back beats
      cur_req = "R9";
      wback(2, 6);
      wback(4, 9);
      for (int w = 0; w < 8; w++) fetch(w, 10, 1, 11, 12);
      cur_req = "R8";
      cyc(36);

      // R2: second fetch to a full slot is dropped
      cur_req = "R2";
      fetch(5, 1, 1, 10, 0);
      fetch(5, 2, 1, 0, 0);
      cyc(2);
      wback(5, 10);
      cyc(6);

      // R5: writebacks to another warp or another register do not clear
      cur_req = "R5";
      fetch(6, 3, 1, 10, 10);
      wback(7, 10);
      wback(6, 11);
      cyc(3);
      check("R5", "unrelated writeback leaves block", int'(issue_valid), 0);
      wback(6, 10);
      cyc(6);

      // R4: destination field ignored when dst_en is low
      cur_req = "R4";
      fetch(1, 10, 0, 0, 0);
      cyc(6);

      // R6 at the last beat: release during final beat of another dispatch
      cur_req = "R6";
      fetch(3, 4, 1, 10, 0);
      fetch(0, 7, 1, 1, 1);
      cyc(2);
      wback(3, 10);
      cyc(10);

      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule